// File: doc/BRIEF.md
# Multi-Output Result Sequencer

This block runs the on-line cycle of a controller that produces several output variables in turn. A rising edge on the start input begins a run. For each output the sequencer issues a request and an output index to an external compute engine. It then waits for that engine's done pulse, captures the 10-bit result, and presents it to the host. The host sees the result with its 4-bit output index and a one-cycle ready strobe. Outputs come in ascending index order, from 0 up to a configured last index. The last index is a 4-bit value holding the count minus one, so one to sixteen outputs are possible.

Two status lines help the host pace itself. The active-low accept line drops as soon as the engine is asked for the final output of a run. The host may then pulse start again. Such an early pulse is held and launches the next run in the cycle after the final result is strobed, so acquisition overlaps the tail of computation. The active-low end flag goes low with the final strobe of a run. It stays low until the next run begins.

The sequencer works only while the off-line enable is low. Raising off-line enable, or pulling the restart line low for a cycle, abandons the run in progress and any held start. The last presented result is kept.

Top module: `result_sequencer`

## Requirements
- R1: A run starts only on a rising edge of `start` (low in one sampled cycle, high in the next). In the cycle after the edge is sampled, `eng_req` is 1 and `eng_idx` is 0. A start held high for many cycles starts exactly one run.
- R2: Within a run, requests and results cover indices 0,1,...,L in ascending order, where L is the value of `cfg_last` captured when the run starts. A later change of `cfg_last` does not affect the run in progress.
- R3: In the cycle after the engine's done is sampled with a request pending, `res_stb` is 1 for one cycle. At that point `res_data` equals the engine result and `res_idx` equals the index that was requested.
- R4: `res_data` and `res_idx` do not change in any cycle where `res_stb` is 0.
- R5: `accept_n` is 0 when no run is active and while the request for index L is outstanding. It is 1 while any earlier index is being requested.
- R6: A start edge that arrives while `accept_n` is 1 during a run is ignored. It neither restarts the run nor queues a new one.
- R7: A start edge that arrives while `accept_n` is 0 during a run is held, including one sampled in the same cycle as the final done. The next run then requests index 0 in the cycle right after the final strobe.
- R8: `end_proc_n` is 1 after reset. It goes to 0 in the same cycle as the strobe of index L, stays 0 while idle, and returns to 1 when a run starts or is aborted.
- R9: While `offline_en` is 1, no request is issued, start edges are ignored, and an active run is abandoned at the next edge. The presented result is kept.
- R10: A cycle with `restart_n` at 0 abandons the active run and any held start. No further strobe follows until a new start edge arrives.
- R11: After `rst`, `res_stb`, `eng_req`, `accept_n`, `res_data` and `res_idx` are 0 and `end_proc_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| offline_en | input | 1 | High holds the sequencer out of on-line operation |
| restart_n | input | 1 | Active-low abort of the current run |
| start | input | 1 | Start of acquisition, acted on at its rising edge |
| cfg_last | input | 4 | Number of outputs minus one |
| eng_req | output | 1 | Request to the compute engine |
| eng_idx | output | 4 | Output index being requested |
| eng_done | input | 1 | Engine finished the requested output |
| eng_result | input | 10 | Engine result, valid with done |
| res_stb | output | 1 | One-cycle strobe for a new result |
| res_data | output | 10 | Presented result |
| res_idx | output | 4 | Index of the presented result |
| accept_n | output | 1 | Low when a new start is accepted |
| end_proc_n | output | 1 | Low when all outputs of the run are done |

## Verification
Two functions can land in one cycle: the arrival of a new start edge and the completion of the final output of a run. The bench provokes this by watching the engine model. It raises start just after the engine asserts done for index L, so that both the edge and the done are sampled at the same clock edge. It then expects three things: the final strobe with `end_proc_n` low in the next cycle, a request for index 0 in the cycle after that, and a complete second run.

// File: rtl/rseq_pkg.sv
package rseq_pkg;

    localparam int RSEQ_RES_W = 10;
    localparam int RSEQ_IDX_W = 4;

    typedef enum logic [0:0] {
        SQ_IDLE = 1'b0,
        SQ_RUN  = 1'b1
    } sq_state_e;

    function automatic logic at_final(input logic [RSEQ_IDX_W-1:0] cur,
                                      input logic [RSEQ_IDX_W-1:0] last);
        return cur == last;
    endfunction

endpackage

// File: rtl/rseq_start_ctl.sv
module rseq_start_ctl (
    input  logic clk,
    input  logic rst,
    input  logic abort,
    input  logic start,
    input  logic final_busy,
    input  logic run_begin,
    output logic go
);
    logic start_q;
    logic pend;
    logic start_edge;

    assign start_edge = start & ~start_q;
    assign go         = (start_edge | pend) & ~abort;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= 1'b0;
            pend    <= 1'b0;
        end else begin
            start_q <= start;
            if (abort)
                pend <= 1'b0;
            else if (start_edge && final_busy)
                pend <= 1'b1;
            else if (run_begin)
                pend <= 1'b0;
        end
    end
endmodule

// File: rtl/rseq_core.sv
module rseq_core
    import rseq_pkg::*;
#(
    parameter int IDX_W = RSEQ_IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             abort,
    input  logic             go,
    input  logic             eng_done,
    input  logic [IDX_W-1:0] cfg_last,
    output logic             eng_req,
    output logic [IDX_W-1:0] eng_idx,
    output logic             final_busy,
    output logic             run_begin,
    output logic             cap,
    output logic             accept_n,
    output logic             end_proc_n
);
    sq_state_e        state;
    logic [IDX_W-1:0] cur;
    logic [IDX_W-1:0] run_last;
    logic             end_q;

    assign final_busy = (state == SQ_RUN) && at_final(cur, run_last);
    assign run_begin  = (state == SQ_IDLE) && go && !abort;
    assign cap        = (state == SQ_RUN) && eng_done && !abort;
    assign eng_req    = (state == SQ_RUN);
    assign eng_idx    = cur;
    assign accept_n   = (state == SQ_RUN) && !final_busy;
    assign end_proc_n = end_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            cur      <= '0;
            run_last <= '0;
            end_q    <= 1'b1;
        end else if (abort) begin
            state <= SQ_IDLE;
            cur   <= '0;
            end_q <= 1'b1;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (go) begin
                        state    <= SQ_RUN;
                        cur      <= '0;
                        run_last <= cfg_last;
                        end_q    <= 1'b1;
                    end
                end
                SQ_RUN: begin
                    if (eng_done) begin
                        if (final_busy) begin
                            state <= SQ_IDLE;
                            end_q <= 1'b0;
                        end else begin
                            cur <= cur + 1'b1;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rseq_result_reg.sv
module rseq_result_reg #(
    parameter int RES_W = 10,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap,
    input  logic [IDX_W-1:0] cap_idx,
    input  logic [RES_W-1:0] cap_val,
    output logic             res_stb,
    output logic [RES_W-1:0] res_data,
    output logic [IDX_W-1:0] res_idx
);
    always_ff @(posedge clk) begin
        if (rst) begin
            res_stb  <= 1'b0;
            res_data <= '0;
            res_idx  <= '0;
        end else begin
            res_stb <= cap;
            if (cap) begin
                res_data <= cap_val;
                res_idx  <= cap_idx;
            end
        end
    end
endmodule

// File: rtl/result_sequencer.sv
module result_sequencer
    import rseq_pkg::*;
#(
    parameter int RES_W = RSEQ_RES_W,
    parameter int IDX_W = RSEQ_IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             offline_en,
    input  logic             restart_n,
    input  logic             start,
    input  logic [IDX_W-1:0] cfg_last,
    output logic             eng_req,
    output logic [IDX_W-1:0] eng_idx,
    input  logic             eng_done,
    input  logic [RES_W-1:0] eng_result,
    output logic             res_stb,
    output logic [RES_W-1:0] res_data,
    output logic [IDX_W-1:0] res_idx,
    output logic             accept_n,
    output logic             end_proc_n
);
    logic abort;
    logic go;
    logic final_busy;
    logic run_begin;
    logic cap;

    assign abort = offline_en | ~restart_n;

    rseq_start_ctl u_start (
        .clk        (clk),
        .rst        (rst),
        .abort      (abort),
        .start      (start),
        .final_busy (final_busy),
        .run_begin  (run_begin),
        .go         (go)
    );

    rseq_core #(.IDX_W(IDX_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .abort      (abort),
        .go         (go),
        .eng_done   (eng_done),
        .cfg_last   (cfg_last),
        .eng_req    (eng_req),
        .eng_idx    (eng_idx),
        .final_busy (final_busy),
        .run_begin  (run_begin),
        .cap        (cap),
        .accept_n   (accept_n),
        .end_proc_n (end_proc_n)
    );

    rseq_result_reg #(.RES_W(RES_W), .IDX_W(IDX_W)) u_res (
        .clk      (clk),
        .rst      (rst),
        .cap      (cap),
        .cap_idx  (eng_idx),
        .cap_val  (eng_result),
        .res_stb  (res_stb),
        .res_data (res_data),
        .res_idx  (res_idx)
    );
endmodule

// File: rtl/rseq_checks.sv
module rseq_checks #(
    parameter int RES_W = 10,
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             offline_en,
    input logic             restart_n,
    input logic             eng_req,
    input logic [IDX_W-1:0] eng_idx,
    input logic             eng_done,
    input logic             res_stb,
    input logic [RES_W-1:0] res_data,
    input logic [IDX_W-1:0] res_idx,
    input logic             accept_n,
    input logic             end_proc_n
);
    // R3
    strobe_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        res_stb |-> ($past(eng_done) && $past(eng_req)));

    // R4
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !res_stb |-> ($stable(res_data) && $stable(res_idx)));

    // R2
    idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_req && $past(eng_req) && $past(eng_done))
            |-> (eng_idx == IDX_W'($past(eng_idx) + 1'b1)));

    // R5
    accept_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !eng_req |-> !accept_n);

    // R8
    end_with_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(end_proc_n) |-> res_stb);

    // R9
    offline_idle_chk: assert property (@(posedge clk) disable iff (rst)
        offline_en |=> !eng_req);

    // R10
    restart_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !restart_n |=> (!eng_req && !res_stb));
endmodule

bind result_sequencer rseq_checks #(.RES_W(RES_W), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .offline_en (offline_en),
    .restart_n  (restart_n),
    .eng_req    (eng_req),
    .eng_idx    (eng_idx),
    .eng_done   (eng_done),
    .res_stb    (res_stb),
    .res_data   (res_data),
    .res_idx    (res_idx),
    .accept_n   (accept_n),
    .end_proc_n (end_proc_n)
);

// File: tb/sim_result_sequencer.sv
`timescale 1ns/1ps
module sim_result_sequencer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       offline_en = 1'b0;
    logic       restart_n = 1'b1;
    logic       start = 1'b0;
    logic [3:0] cfg_last = 4'd0;
    logic       eng_req;
    logic [3:0] eng_idx;
    logic       eng_done = 1'b0;
    logic [9:0] eng_result = 10'd0;
    logic       res_stb;
    logic [9:0] res_data;
    logic [3:0] res_idx;
    logic       accept_n;
    logic       end_proc_n;

    always #4 clk = ~clk;

    result_sequencer u0 (
        .clk(clk), .rst(rst), .offline_en(offline_en), .restart_n(restart_n),
        .start(start), .cfg_last(cfg_last), .eng_req(eng_req), .eng_idx(eng_idx),
        .eng_done(eng_done), .eng_result(eng_result), .res_stb(res_stb),
        .res_data(res_data), .res_idx(res_idx), .accept_n(accept_n),
        .end_proc_n(end_proc_n)
    );

    int checks = 0;
    int errors = 0;
    int lat = 1;
    int tag = 0;
    int ecnt = 0;
    bit acc_en = 1'b1;
    logic [9:0] lg_data [0:63];
    logic [3:0] lg_idx  [0:63];
    int lg_n = 0;
    logic [9:0] held_d = 10'd0;
    logic [3:0] held_i = 4'd0;

    // {last index, engine latency}
    localparam logic [7:0] VEC [0:4] = '{
        {4'd0, 4'd1}, {4'd3, 4'd2}, {4'd15, 4'd1}, {4'd5, 4'd4}, {4'd2, 4'd0}
    };

    function automatic logic [9:0] fres(input logic [3:0] i);
        return 10'((int'(i) * 41 + tag * 7) % 1024);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        tick();
        start = 1'b0;
    endtask

    task automatic wait_strobes(input int n, input int maxc);
        for (int c = 0; c < maxc && lg_n < n; c++) tick();
    endtask

    // engine model
    initial begin
        forever begin
            @(negedge clk);
            if (rst) begin
                eng_done = 1'b0;
                ecnt = 0;
            end else if (eng_done) begin
                eng_done = 1'b0;
                ecnt = 0;
            end else if (eng_req) begin
                if (ecnt >= lat) begin
                    eng_done = 1'b1;
                    eng_result = fres(eng_idx);
                end else begin
                    ecnt++;
                end
            end else begin
                ecnt = 0;
            end
        end
    end

    // output monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst) begin
                if (res_stb) begin
                    if (lg_n < 64) begin
                        lg_data[lg_n] = res_data;
                        lg_idx[lg_n]  = res_idx;
                    end
                    lg_n++;
                    chk(eng_done && res_data == eng_result, "R3 strobe data", res_data, eng_result);
                    held_d = res_data;
                    held_i = res_idx;
                end else begin
                    chk(res_data == held_d && res_idx == held_i, "R4 hold", res_data, held_d);
                end
                if (acc_en)
                    chk(accept_n == (eng_req && eng_idx != cfg_last), "R5 accept",
                        accept_n, (eng_req && eng_idx != cfg_last));
            end
        end
    end

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R11 reset state
        chk(res_stb == 0 && eng_req == 0 && accept_n == 0, "R11 controls", {res_stb, eng_req, accept_n}, 0);
        chk(res_data == 0 && res_idx == 0, "R11 result", res_data, 0);
        chk(end_proc_n == 1, "R8 end after reset", end_proc_n, 1);

        // table of runs: R1 R2 R3 R8
        for (int v = 0; v < 5; v++) begin
            cfg_last = VEC[v][7:4];
            lat = int'(VEC[v][3:0]);
            tag = v + 1;
            lg_n = 0;
            pulse_start();
            chk(eng_req == 1 && eng_idx == 0, "R1 first request", eng_idx, 0);
            chk(end_proc_n == 1, "R8 high in run", end_proc_n, 1);
            wait_strobes(int'(cfg_last) + 1, 400);
            repeat (3) tick();
            chk(lg_n == int'(cfg_last) + 1, "R2 count", lg_n, int'(cfg_last) + 1);
            for (int k = 0; k <= int'(cfg_last); k++) begin
                chk(lg_idx[k] == 4'(k), "R2 order", lg_idx[k], k);
                chk(lg_data[k] == fres(4'(k)), "R3 value", lg_data[k], fres(4'(k)));
            end
            chk(end_proc_n == 0 && eng_req == 0, "R8 end low idle", end_proc_n, 0);
        end

        // R2 config captured at start
        acc_en = 1'b0;
        cfg_last = 4'd2; lat = 1; lg_n = 0;
        pulse_start();
        cfg_last = 4'd9;
        wait_strobes(10, 200);
        chk(lg_n == 3, "R2 captured config", lg_n, 3);
        cfg_last = 4'd2;
        tick();
        acc_en = 1'b1;

        // R1 held start gives one run
        cfg_last = 4'd0; lat = 1; lg_n = 0;
        start = 1'b1;
        repeat (30) tick();
        start = 1'b0;
        repeat (5) tick();
        chk(lg_n == 1, "R1 held start", lg_n, 1);

        // R6 start ignored while accept_n high
        cfg_last = 4'd7; lat = 3; lg_n = 0;
        pulse_start();
        repeat (4) tick();
        chk(accept_n == 1, "R6 accept high", accept_n, 1);
        pulse_start();
        wait_strobes(8, 400);
        repeat (20) tick();
        chk(lg_n == 8 && eng_req == 0, "R6 no extra run", lg_n, 8);

        // R7 early start queued
        cfg_last = 4'd3; lat = 3; lg_n = 0;
        pulse_start();
        for (int c = 0; c < 200 && !(eng_req && !accept_n); c++) tick();
        chk(eng_idx == 3, "R5 low on last", eng_idx, 3);
        pulse_start();
        wait_strobes(4, 200);
        chk(res_idx == 3 && end_proc_n == 0, "R8 end with last strobe", end_proc_n, 0);
        tick();
        chk(eng_req == 1 && eng_idx == 0 && end_proc_n == 1, "R7 chained run", eng_idx, 0);
        wait_strobes(8, 400);
        repeat (5) tick();
        chk(lg_n == 8 && lg_idx[4] == 0 && lg_idx[7] == 3, "R7 second run", lg_n, 8);

        // R7 start in same cycle as final done
        cfg_last = 4'd2; lat = 2; lg_n = 0;
        pulse_start();
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            #1;
            if (eng_done && eng_idx == 4'd2) break;
        end
        start = 1'b1;
        @(posedge clk);
        #2;
        start = 1'b0;
        chk(res_stb == 1 && res_idx == 2 && end_proc_n == 0, "R7 coincident strobe", res_idx, 2);
        tick();
        chk(eng_req == 1 && eng_idx == 0, "R7 coincident relaunch", eng_idx, 0);
        wait_strobes(6, 300);
        repeat (5) tick();
        chk(lg_n == 6 && lg_idx[3] == 0, "R7 coincident second run", lg_n, 6);

        // R9 off-line abort
        cfg_last = 4'd7; lat = 2; lg_n = 0;
        pulse_start();
        wait_strobes(3, 200);
        tick();
        held_d = res_data;
        offline_en = 1'b1;
        tick();
        chk(eng_req == 0 && accept_n == 0 && end_proc_n == 1, "R9 abort", eng_req, 0);
        pulse_start();
        repeat (10) tick();
        chk(eng_req == 0 && lg_n == 3, "R9 start ignored", lg_n, 3);
        chk(res_data == held_d, "R9 result kept", res_data, held_d);
        offline_en = 1'b0;
        tick();
        lg_n = 0;
        pulse_start();
        chk(eng_req == 1 && eng_idx == 0, "R9 resume", eng_idx, 0);
        wait_strobes(8, 400);
        repeat (3) tick();

        // R10 restart clears run and held start
        cfg_last = 4'd1; lat = 5; lg_n = 0;
        pulse_start();
        for (int c = 0; c < 200 && !(eng_req && !accept_n); c++) tick();
        pulse_start();
        restart_n = 1'b0;
        tick();
        restart_n = 1'b1;
        chk(eng_req == 0 && end_proc_n == 1, "R10 abort", eng_req, 0);
        repeat (20) tick();
        chk(lg_n == 1 && eng_req == 0, "R10 held start dropped", lg_n, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule